// File: doc/BRIEF.md
# Programmable Display State Sequencer

This block walks a display through a short, software-defined list of up to eight states. Each state is a six-bit word held in a small writable memory. The word names the vertical channel to show, chooses between the main and the delayed sweep, drives a delay-select line and can mark itself as the final state of the list. After the final state, the walk starts again at address 0.

The event that moves the walk forward depends on the operating mode. In the two alternate modes, holdoff rising edges advance the walk, either on every edge or on every second edge. In the auto-alternate mode, the horizontal bits flip on each holdoff edge and the vertical state moves only when the display goes from the delayed sweep back to the main sweep. In chop mode, chop-blanking edges step the vertical state and holdoff edges flip the horizontal bits.

A processor loads the memory through a write port that is gated by a program-enable input. A sequence-reset strobe puts the walk back to its first programmed state. The holdoff and chop inputs are asynchronous. Each passes through a two-stage synchronizer and a rising-edge detector in the system clock domain.

Top module: `disp_seq`

## Requirements
- R1: After `rst_n` is low at a clock edge, every memory word is zero and the pointer is at address 0. The outputs are then `chan_sel`=000, `hdisp`=10 and `dly_sel`=0.
- R2: The current state word drives the outputs as follows. Bits 5:3 go to `chan_sel`, with the codes 000=channel 1, 001=channel 2, 010=channels 1 and 2, 011=channel 3 and 100=channel 4. In modes 00 and 01, bit 2 drives `hdisp`: high gives 01 (main sweep) and low gives 10 (delayed sweep). In modes 00, 01 and 10, bit 1 drives `dly_sel`. Bit 0 is the last-state flag.
- R3: In mode 00, every rising edge of `holdoff_in` advances the pointer by one. The outputs show the new state three clock edges after the input rises.
- R4: An advance taken from a word whose bit 0 is set returns the pointer to address 0. Without that flag, the pointer steps from address 7 to address 0.
- R5: In mode 01, the pointer advances only on every second holdoff rising edge. The edge-phase flag is cleared by `seq_rst`.
- R6: In mode 10, `hdisp` toggles between 01 and 10 on each holdoff rising edge, starting at 01. The pointer advances only on the edge that takes `hdisp` from 10 to 01.
- R7: In mode 11, each rising edge of `chop_in` advances the pointer and holdoff edges do not move it. `dly_sel` is held at 0. Word bit 2 has no effect. `hdisp` toggles on each holdoff rising edge, as in R6.
- R8: A one-cycle `seq_rst` puts the pointer at address 0, clears the phase flag and selects the main sweep for the toggling modes. If `holdoff_in` is held high across the strobe and released afterwards, no advance follows.
- R9: A write stores `wr_data` at `wr_addr` only when `wr_en` and `prog_en` are both high. A write never moves the pointer. A write to the current address shows on the outputs on the next cycle.
- R10: `hdisp` is always either 01 or 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of memory and sequence state |
| seq_rst | input | 1 | Sequence restart strobe, active high |
| mode | input | 2 | 00 alternate every edge, 01 alternate every second edge, 10 auto-alternate, 11 chop |
| prog_en | input | 1 | Permits memory writes |
| wr_en | input | 1 | Memory write strobe |
| wr_addr | input | 3 | Memory write address |
| wr_data | input | 6 | State word to store |
| holdoff_in | input | 1 | Asynchronous trigger holdoff signal |
| chop_in | input | 1 | Asynchronous chop blanking signal |
| chan_sel | output | 3 | Vertical channel code |
| hdisp | output | 2 | Horizontal display bits (01 main, 10 delayed) |
| dly_sel | output | 1 | Delay-select output |

## Verification
The bench writes a three-state list whose last word carries the return flag. This would expose a pointer that ran on to address 3 instead of returning to address 0. In the every-second-edge mode, the first pulse must leave the channel unchanged, so a missing phase flag or one that survives a restart shows up as an early advance. In auto-alternate mode, the bench checks that the vertical state holds on the main-to-delayed flip and moves on the delayed-to-main flip. In chop mode, it checks that holdoff pulses do not step the channel and that the delay-select bit of the word is suppressed. Gated writes and a write to the live address must leave the pointer in place. A restart strobed while holdoff is held high must not produce a stray advance when holdoff is released.

// File: rtl/disp_seq.sv
module disp_seq #(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst,
  input  logic [1:0]        mode,
  input  logic              prog_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [5:0]        wr_data,
  input  logic              holdoff_in,
  input  logic              chop_in,
  output logic [2:0]        chan_sel,
  output logic [1:0]        hdisp,
  output logic              dly_sel
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] M_EACH = 2'b00, M_PAIR = 2'b01, M_AUTO = 2'b10, M_CHOP = 2'b11;

  logic [5:0]             mem [DEPTH];
  logic [ADDR_W-1:0]      ptr;
  logic [SYNC_STAGES-1:0] ho_sync, ch_sync;
  logic                   ho_prev, ch_prev;
  logic                   div_q, hsel;
  logic                   ho_edge, chop_edge, adv, last;
  logic [5:0]             word;

  assign word      = mem[ptr];
  assign last      = word[0];
  assign ho_edge   = ho_sync[SYNC_STAGES-1] & ~ho_prev;
  assign chop_edge = ch_sync[SYNC_STAGES-1] & ~ch_prev;

  always_comb begin
    unique case (mode)
      M_EACH:  adv = ho_edge;
      M_PAIR:  adv = ho_edge & div_q;
      M_AUTO:  adv = ho_edge & ~hsel;
      default: adv = chop_edge;
    endcase
  end

  logic use_hsel;
  assign use_hsel = (mode == M_AUTO) || (mode == M_CHOP);
  assign chan_sel = word[5:3];
  assign hdisp    = (use_hsel ? hsel : word[2]) ? 2'b01 : 2'b10;
  assign dly_sel  = (mode != M_CHOP) & word[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr     <= '0;
      ho_sync <= '0;
      ch_sync <= '0;
      ho_prev <= 1'b0;
      ch_prev <= 1'b0;
      div_q   <= 1'b0;
      hsel    <= 1'b1;
    end else begin
      ho_sync <= {ho_sync[SYNC_STAGES-2:0], holdoff_in};
      ch_sync <= {ch_sync[SYNC_STAGES-2:0], chop_in};
      ho_prev <= ho_sync[SYNC_STAGES-1];
      ch_prev <= ch_sync[SYNC_STAGES-1];
      if (wr_en && prog_en) mem[wr_addr] <= wr_data;
      if (seq_rst) begin
        ptr   <= '0;
        div_q <= 1'b0;
        hsel  <= 1'b1;
      end else begin
        if (adv) ptr <= last ? '0 : ptr + 1'b1;
        if (ho_edge && mode == M_PAIR) div_q <= ~div_q;
        if (ho_edge && use_hsel) hsel <= ~hsel;
      end
    end
  end
endmodule

// File: rtl/disp_seq_chk.sv
module disp_seq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seq_rst,
  input logic [1:0]    mode,
  input logic [1:0]    hdisp,
  input logic          dly_sel,
  input logic [AW-1:0] ptr,
  input logic          adv,
  input logic          last,
  input logic          ho_edge,
  input logic          div_q
);
  // R10
  hdisp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hdisp) == 1);

  // R8
  restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst |=> ptr == '0);

  // R4
  last_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last && !seq_rst) |=> ptr == '0);

  // R5
  pair_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && ho_edge && !div_q && !seq_rst) |=> $stable(ptr));

  // R7
  chop_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> !dly_sel);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !seq_rst) |=> $stable(ptr));
endmodule

bind disp_seq disp_seq_chk #(.AW(ADDR_W)) chk (.*);

// File: tb/disp_seq_test.sv
module disp_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, seq_rst = 1'b0;
  logic [1:0] mode = 2'b00;
  logic prog_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic holdoff_in = 1'b0, chop_in = 1'b0;
  logic [2:0] chan_sel;
  logic [1:0] hdisp;
  logic dly_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_seq uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(logic pe, logic [2:0] a, logic [5:0] d);
    @(negedge clk); prog_en = pe; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; prog_en = 1'b0;
  endtask

  task automatic restart(logic [1:0] m);
    @(negedge clk); mode = m; seq_rst = 1'b1;
    @(negedge clk); seq_rst = 1'b0;
  endtask

  task automatic ho_pulse();
    @(negedge clk); holdoff_in = 1'b1;
    repeat (4) @(negedge clk);
    holdoff_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic chop_pulse();
    @(negedge clk); chop_in = 1'b1;
    repeat (4) @(negedge clk);
    chop_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 chan", chan_sel, 0);
    chk("R1 hdisp", hdisp, 2);
    chk("R1 dly", dly_sel, 0);
  endtask

  task automatic t_decode();
    put(1, 3'd0, 6'b001110);
    put(1, 3'd1, 6'b011000);
    put(1, 3'd2, 6'b100101);
    put(1, 3'd3, 6'b010110);
    restart(2'b00);
    chk("R2 chan", chan_sel, 1);
    chk("R2 hdisp A", hdisp, 1);
    chk("R2 dly", dly_sel, 1);
  endtask

  task automatic t_each();
    @(negedge clk); holdoff_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 not yet", chan_sel, 1);
    @(negedge clk);
    chk("R3 third edge", chan_sel, 3);
    holdoff_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 hdisp B", hdisp, 2);
    chk("R2 dly low", dly_sel, 0);
    ho_pulse();
    chk("R3 step2", chan_sel, 4);
    ho_pulse();
    chk("R4 return", chan_sel, 1);
  endtask

  task automatic t_pair();
    restart(2'b00);
    ho_pulse();
    restart(2'b01);
    ho_pulse();
    chk("R5 first edge", chan_sel, 1);
    ho_pulse();
    chk("R5 second edge", chan_sel, 3);
    ho_pulse();
    restart(2'b01);
    ho_pulse();
    chk("R5 phase cleared", chan_sel, 1);
  endtask

  task automatic t_auto();
    restart(2'b10);
    chk("R6 start A", hdisp, 1);
    ho_pulse();
    chk("R6 to B", hdisp, 2);
    chk("R6 hold", chan_sel, 1);
    ho_pulse();
    chk("R6 back A", hdisp, 1);
    chk("R6 advance", chan_sel, 3);
  endtask

  task automatic t_chop();
    restart(2'b11);
    chk("R7 dly off", dly_sel, 0);
    chk("R7 hdisp", hdisp, 1);
    chop_pulse();
    chk("R7 chop step", chan_sel, 3);
    ho_pulse();
    chk("R7 ho no step", chan_sel, 3);
    chk("R7 ho toggles", hdisp, 2);
    chop_pulse();
    chop_pulse();
    chk("R7 last wrap", chan_sel, 1);
  endtask

  task automatic t_prog();
    put(0, 3'd0, 6'b111111);
    restart(2'b00);
    chk("R9 gated", chan_sel, 1);
    ho_pulse();
    put(1, 3'd1, 6'b000100);
    chk("R9 live chan", chan_sel, 0);
    chk("R9 live hdisp", hdisp, 1);
    ho_pulse();
    chk("R9 ptr kept", chan_sel, 4);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) put(1, 3'(i), {3'(i % 5), 3'b000});
    restart(2'b00);
    for (int i = 0; i < 7; i++) ho_pulse();
    chk("R4 at seven", chan_sel, 2);
    ho_pulse();
    chk("R4 seven wraps", chan_sel, 0);
  endtask

  task automatic t_init();
    put(1, 3'd0, 6'b001110);
    put(1, 3'd1, 6'b011000);
    restart(2'b00);
    ho_pulse();
    @(negedge clk); holdoff_in = 1'b1;
    repeat (4) @(negedge clk);
    seq_rst = 1'b1;
    @(negedge clk); seq_rst = 1'b0;
    repeat (2) @(negedge clk);
    holdoff_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 init chan", chan_sel, 1);
    chk("R8 init dly", dly_sel, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_each();
    t_pair();
    t_auto();
    t_chop();
    t_prog();
    t_init();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule